// File: doc/BRIEF.md
# Speculative Banked Store Forwarding Buffer

This block keeps recently executed stores close to a multibanked first-level data cache so that later loads can take their data without waiting for the stores to reach the cache. It is split into small banks. Each bank sits beside one cache bank and owns the doubleword addresses that map to that cache bank. A store claims a slot only at the moment it executes. Each slot holds the doubleword address, a 64-bit data word, a byte mask and the store's sequence tag.

A load probes the bank that owns its address, and the result comes back combinationally in the same cycle, which matches the timing of a cache bank read. Forwarding is speculative. The load port carries no age information, so any held store to the same doubleword may supply data. A later, separate structure checks ordering. When a bank is full, the slot allocated longest ago is overwritten, so store execution never waits. A squash port removes every held store at or after a given sequence tag.

Each slot is a two-state machine. `SLOT_EMPTY` moves to `SLOT_HELD` on the *alloc* transition. `SLOT_HELD` stays in `SLOT_HELD` on *overwrite* (alloc again) and returns to `SLOT_EMPTY` on the *kill* transition, which is a squash whose tag is less than or equal to the slot's tag.

Top module: `spec_store_fwd`

## Requirements
- R1: After reset every slot is empty, and no load hits until a store has been allocated.
- R2: Addresses are doubleword indices. The bank that owns an address is given by its low log2(NB) bits (bits 1:0 with four banks), and stores and loads use only that bank.
- R3: A store accepted at a clock edge can be forwarded to a load probed in the next cycle. ld_hit, ld_data and ld_tag depend combinationally on the load inputs, and no age check is made between load and store.
- R4: Each bank allocates slots in round-robin order. The ninth store into a full 8-slot bank replaces the store allocated longest ago in that bank, and the other banks are not touched.
- R5: When several held stores match the load address, the one allocated most recently decides the result, and ld_tag returns its sequence tag.
- R6: A load hits only if ld_mask is nonzero and every requested byte (bit i of a mask is byte i of the word) is set in the deciding store's mask. Otherwise the load misses, even if an older store covers the bytes.
- R7: ld_hit is 0 whenever ld_valid is 0. ld_data and ld_tag are 0 whenever ld_hit is 0.
- R8: A squash with sequence tag S empties, in one cycle, every held slot whose tag is greater than or equal to S (unsigned compare). Slots with smaller tags stay.
- R9: A store presented in the same cycle as a squash is dropped when its tag is greater than or equal to S, and the round-robin pointer does not move. Otherwise it is allocated normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_valid | input | 1 | A store executes this cycle |
| st_addr | input | AW (32) | Store doubleword address |
| st_data | input | DW (64) | Store data word |
| st_mask | input | DW/8 (8) | Store byte mask |
| st_tag | input | TW (8) | Store sequence tag |
| sq_valid | input | 1 | Squash request |
| sq_tag | input | TW (8) | Squash boundary tag |
| ld_valid | input | 1 | Load probe this cycle |
| ld_addr | input | AW (32) | Load doubleword address |
| ld_mask | input | DW/8 (8) | Bytes the load requests |
| ld_hit | output | 1 | Forwarding succeeded |
| ld_data | output | DW (64) | Forwarded data word |
| ld_tag | output | TW (8) | Tag of the forwarding store |

## Verification
A store and a squash can arrive in the same cycle, and the result depends on how the incoming tag compares with the squash tag. The bench provokes this case directly with tags just below, equal to and above the boundary. Random traffic also mixes squashes with stores whose tags lie near the boundary. The outcome is judged in the following cycle by loads to the stored address, compared with a bench model that applies the kill and then the allocation in the order the requirements give.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    localparam int DEF_AW = 32;
    localparam int DEF_DW = 64;
    localparam int DEF_NB = 4;
    localparam int DEF_NE = 8;
    localparam int DEF_TW = 8;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/sfb_slot.sv
module sfb_slot
    import sfb_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int DW = DEF_DW,
    parameter int TW = DEF_TW,
    localparam int MW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [MW-1:0] wr_mask,
    input  logic [TW-1:0] wr_tag,
    input  logic          kill_en,
    input  logic [TW-1:0] kill_tag,
    output logic          held,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic [MW-1:0] mask,
    output logic [TW-1:0] tag
);
    slot_state_e state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [MW-1:0] mask_q;
    logic [TW-1:0] tag_q;

    // next-state: alloc, overwrite, kill
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (wr_en) state_d = SLOT_HELD;
            end
            SLOT_HELD: begin
                if (wr_en)                              state_d = SLOT_HELD;
                else if (kill_en && (tag_q >= kill_tag)) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // payload captured on alloc/overwrite
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            mask_q <= '0;
            tag_q  <= '0;
        end else if (wr_en) begin
            addr_q <= wr_addr;
            data_q <= wr_data;
            mask_q <= wr_mask;
            tag_q  <= wr_tag;
        end
    end

    // outputs
    always_comb begin
        held = (state_q == SLOT_HELD);
        addr = addr_q;
        data = data_q;
        mask = mask_q;
        tag  = tag_q;
    end
endmodule

// File: rtl/sfb_bank.sv
module sfb_bank
    import sfb_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int DW = DEF_DW,
    parameter int TW = DEF_TW,
    parameter int NE = DEF_NE,
    localparam int MW = DW / 8,
    localparam int EB = $clog2(NE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [MW-1:0] st_mask,
    input  logic [TW-1:0] st_tag,
    input  logic          kill_en,
    input  logic [TW-1:0] kill_tag,
    input  logic [AW-1:0] pr_addr,
    input  logic [MW-1:0] pr_mask,
    output logic          pr_hit,
    output logic [DW-1:0] pr_data,
    output logic [TW-1:0] pr_tag
);
    logic [EB-1:0] ptr_q;
    logic          s_held [NE];
    logic [AW-1:0] s_addr [NE];
    logic [DW-1:0] s_data [NE];
    logic [MW-1:0] s_mask [NE];
    logic [TW-1:0] s_tag  [NE];

    for (genvar g = 0; g < NE; g++) begin : g_slot
        sfb_slot #(.AW(AW), .DW(DW), .TW(TW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (alloc && (ptr_q == EB'(g))),
            .wr_addr (st_addr),
            .wr_data (st_data),
            .wr_mask (st_mask),
            .wr_tag  (st_tag),
            .kill_en (kill_en),
            .kill_tag(kill_tag),
            .held    (s_held[g]),
            .addr    (s_addr[g]),
            .data    (s_data[g]),
            .mask    (s_mask[g]),
            .tag     (s_tag[g])
        );
    end

    // round-robin pointer: points at the slot allocated longest ago
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr_q <= '0;
        else if (alloc) ptr_q <= ptr_q + EB'(1);
    end

    // youngest-first search, walking back from the pointer
    always_comb begin
        logic          found;
        logic [EB-1:0] idx;
        logic [MW-1:0] f_mask;
        logic [DW-1:0] f_data;
        logic [TW-1:0] f_tag;
        found  = 1'b0;
        idx    = '0;
        f_mask = '0;
        f_data = '0;
        f_tag  = '0;
        for (int k = 0; k < NE; k++) begin
            idx = ptr_q - EB'(1) - EB'(k);
            if (!found && s_held[idx] && (s_addr[idx] == pr_addr)) begin
                found  = 1'b1;
                f_mask = s_mask[idx];
                f_data = s_data[idx];
                f_tag  = s_tag[idx];
            end
        end
        pr_hit  = found && (pr_mask != '0) && ((pr_mask & ~f_mask) == '0);
        pr_data = pr_hit ? f_data : '0;
        pr_tag  = pr_hit ? f_tag  : '0;
    end
endmodule

// File: rtl/spec_store_fwd.sv
module spec_store_fwd
    import sfb_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int DW = DEF_DW,
    parameter int NB = DEF_NB,
    parameter int NE = DEF_NE,
    parameter int TW = DEF_TW,
    localparam int MW = DW / 8,
    localparam int BB = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [MW-1:0] st_mask,
    input  logic [TW-1:0] st_tag,
    input  logic          sq_valid,
    input  logic [TW-1:0] sq_tag,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [MW-1:0] ld_mask,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    output logic [TW-1:0] ld_tag
);
    logic [BB-1:0] st_bank, ld_bank;
    logic          st_drop;
    logic          b_hit  [NB];
    logic [DW-1:0] b_data [NB];
    logic [TW-1:0] b_tag  [NB];

    assign st_bank = st_addr[BB-1:0];
    assign ld_bank = ld_addr[BB-1:0];
    assign st_drop = sq_valid && (st_tag >= sq_tag);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sfb_bank #(.AW(AW), .DW(DW), .TW(TW), .NE(NE)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc   (st_valid && !st_drop && (st_bank == BB'(b))),
            .st_addr (st_addr),
            .st_data (st_data),
            .st_mask (st_mask),
            .st_tag  (st_tag),
            .kill_en (sq_valid),
            .kill_tag(sq_tag),
            .pr_addr (ld_addr),
            .pr_mask (ld_mask),
            .pr_hit  (b_hit[b]),
            .pr_data (b_data[b]),
            .pr_tag  (b_tag[b])
        );
    end

    always_comb begin
        ld_hit  = ld_valid && b_hit[ld_bank];
        ld_data = ld_hit ? b_data[ld_bank] : '0;
        ld_tag  = ld_hit ? b_tag[ld_bank]  : '0;
    end
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
    parameter int AW = 32,
    parameter int DW = 64,
    parameter int TW = 8,
    localparam int MW = DW / 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          sq_valid,
    input logic [TW-1:0] sq_tag,
    input logic          ld_valid,
    input logic [AW-1:0] ld_addr,
    input logic [MW-1:0] ld_mask,
    input logic          ld_hit,
    input logic [DW-1:0] ld_data,
    input logic [TW-1:0] ld_tag
);
    assert_no_hit_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !ld_hit);

    assert_zero_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_hit |-> (ld_data == '0) && (ld_tag == '0));

    assert_empty_mask_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mask == '0) |-> !ld_hit);

    assert_squash_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> !(ld_hit && (ld_tag >= $past(sq_tag))));

    assert_quiet_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(st_valid) && !$past(sq_valid) && $stable(ld_valid)
         && $stable(ld_addr) && $stable(ld_mask))
        |-> ($stable(ld_hit) && $stable(ld_data) && $stable(ld_tag)));
endmodule

bind spec_store_fwd sfb_checker #(.AW(AW), .DW(DW), .TW(TW)) u_sfb_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_valid(st_valid),
    .sq_valid(sq_valid),
    .sq_tag  (sq_tag),
    .ld_valid(ld_valid),
    .ld_addr (ld_addr),
    .ld_mask (ld_mask),
    .ld_hit  (ld_hit),
    .ld_data (ld_data),
    .ld_tag  (ld_tag)
);

// File: tb/tb_spec_store_fwd.sv
`timescale 1ns/1ps
module tb_spec_store_fwd;
    localparam int AW = 32, DW = 64, NB = 4, NE = 8, TW = 8, MW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [MW-1:0] st_mask = '0;
    logic [TW-1:0] st_tag = '0;
    logic          sq_valid = 1'b0;
    logic [TW-1:0] sq_tag = '0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [MW-1:0] ld_mask = '0;
    logic          ld_hit;
    logic [DW-1:0] ld_data;
    logic [TW-1:0] ld_tag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spec_store_fwd #(.AW(AW), .DW(DW), .NB(NB), .NE(NE), .TW(TW)) dut (.*);

    // bench model built from the requirements
    bit            m_held [NB][NE];
    logic [AW-1:0] m_addr [NB][NE];
    logic [DW-1:0] m_data [NB][NE];
    logic [MW-1:0] m_mask [NB][NE];
    logic [TW-1:0] m_tag  [NB][NE];
    int            m_ptr  [NB];

    function automatic void model_reset();
        for (int b = 0; b < NB; b++) begin
            m_ptr[b] = 0;
            for (int e = 0; e < NE; e++) m_held[b][e] = 1'b0;
        end
    endfunction

    function automatic logic [DW+TW:0] model_probe(logic v, logic [AW-1:0] a, logic [MW-1:0] m);
        int b;
        b = int'(a % NB);
        for (int k = 0; k < NE; k++) begin
            int i;
            i = (m_ptr[b] - 1 - k + 2*NE) % NE;
            if (m_held[b][i] && m_addr[b][i] == a) begin
                if (v && m != 0 && ((m & ~m_mask[b][i]) == 0))
                    return {1'b1, m_tag[b][i], m_data[b][i]};
                return '0;
            end
        end
        return '0;
    endfunction

    function automatic void model_edge();
        if (sq_valid)
            for (int b = 0; b < NB; b++)
                for (int e = 0; e < NE; e++)
                    if (m_held[b][e] && m_tag[b][e] >= sq_tag) m_held[b][e] = 1'b0;
        if (st_valid && !(sq_valid && st_tag >= sq_tag)) begin
            int b;
            b = int'(st_addr % NB);
            m_held[b][m_ptr[b]] = 1'b1;
            m_addr[b][m_ptr[b]] = st_addr;
            m_data[b][m_ptr[b]] = st_data;
            m_mask[b][m_ptr[b]] = st_mask;
            m_tag[b][m_ptr[b]]  = st_tag;
            m_ptr[b] = (m_ptr[b] + 1) % NE;
        end
    endfunction

    task automatic step(input logic sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                        input logic [MW-1:0] sm, input logic [TW-1:0] stg,
                        input logic qv, input logic [TW-1:0] qt,
                        input logic lv, input logic [AW-1:0] la, input logic [MW-1:0] lm,
                        input string req);
        logic [DW+TW:0] exp, act;
        st_valid = sv; st_addr = sa; st_data = sd; st_mask = sm; st_tag = stg;
        sq_valid = qv; sq_tag = qt;
        ld_valid = lv; ld_addr = la; ld_mask = lm;
        #2;
        exp = model_probe(lv, la, lm);
        act = {ld_hit, ld_tag, ld_data};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s addr=%0d hit/tag/data actual=%0b/%0h/%0h expected=%0b/%0h/%0h",
                     req, la, act[DW+TW], act[DW+TW-1:DW], act[DW-1:0],
                     exp[DW+TW], exp[DW+TW-1:DW], exp[DW-1:0]);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic ld(input logic [AW-1:0] a, input logic [MW-1:0] m, input string req);
        step(1'b0, '0, '0, '0, '0, 1'b0, '0, 1'b1, a, m, req);
    endtask

    task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [MW-1:0] m,
                      input logic [TW-1:0] t, input string req);
        step(1'b1, a, d, m, t, 1'b0, '0, 1'b0, '0, '0, req);
    endtask

    initial begin
        logic [TW-1:0] tctr;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        ld(32'd5, 8'hFF, "R1");
        ld(32'd0, 8'h01, "R1");
        // R3: store then forward next cycle
        st(32'd4, 64'hA0A0_1111_2222_3333, 8'hFF, 8'd1, "R3");
        ld(32'd4, 8'h0F, "R3");
        // R7: idle load port
        step(1'b0, '0, '0, '0, '0, 1'b0, '0, 1'b0, 32'd4, 8'hFF, "R7");
        // R5: youngest same-address store wins
        st(32'd4, 64'hB0B0_4444_5555_6666, 8'hFF, 8'd2, "R5");
        ld(32'd4, 8'hFF, "R5");
        // R6: partial younger store blocks forwarding
        st(32'd4, 64'hC0C0_7777_8888_9999, 8'h0F, 8'd3, "R6");
        ld(32'd4, 8'hFF, "R6");
        ld(32'd4, 8'h03, "R6");
        ld(32'd4, 8'h00, "R6");
        // R2/R4: fill bank 1, then overflow
        for (int k = 0; k < NE; k++) st(32'(1 + 4*k), 64'(100 + k), 8'hFF, 8'(10 + k), "R4");
        ld(32'd1, 8'hFF, "R4");
        st(32'd33, 64'hDEAD, 8'hFF, 8'd20, "R4");
        ld(32'd1, 8'hFF, "R4");
        ld(32'd5, 8'hFF, "R4");
        ld(32'd33, 8'hFF, "R4");
        ld(32'd4, 8'h01, "R2");
        ld(32'd2, 8'hFF, "R2");
        // R8: squash at tag 15 and above
        step(1'b0, '0, '0, '0, '0, 1'b1, 8'd15, 1'b0, '0, '0, "R8");
        ld(32'd29, 8'hFF, "R8");
        ld(32'd33, 8'hFF, "R8");
        ld(32'd17, 8'hFF, "R8");
        // R9: store concurrent with squash, below / equal / above boundary
        step(1'b1, 32'd6, 64'h6, 8'hFF, 8'd9, 1'b1, 8'd10, 1'b0, '0, '0, "R9");
        ld(32'd6, 8'hFF, "R9");
        step(1'b1, 32'd7, 64'h7, 8'hFF, 8'd10, 1'b1, 8'd10, 1'b0, '0, '0, "R9");
        ld(32'd7, 8'hFF, "R9");
        step(1'b1, 32'd10, 64'hA, 8'hFF, 8'd30, 1'b1, 8'd10, 1'b1, 32'd6, 8'hFF, "R9");
        ld(32'd10, 8'hFF, "R9");

        // random traffic
        tctr = 8'd40;
        for (int n = 0; n < 4000; n++) begin
            logic sv, qv, lv;
            logic [MW-1:0] sm, lm;
            logic [TW-1:0] qt;
            sv = ($urandom % 3) != 0;
            qv = ($urandom % 25) == 0;
            lv = ($urandom % 4) != 0;
            case ($urandom % 4)
                0: sm = 8'hFF; 1: sm = 8'h0F; 2: sm = 8'hF0; default: sm = 8'($urandom);
            endcase
            case ($urandom % 4)
                0: lm = 8'hFF; 1: lm = 8'h0F; 2: lm = 8'h01; default: lm = 8'($urandom);
            endcase
            qt = tctr - 8'($urandom % 6);
            step(sv, 32'($urandom % 14), {$urandom, $urandom}, sm, tctr, qv, qt,
                 lv, 32'($urandom % 14), lm, "R3");
            if (sv) tctr = tctr + 8'd1;
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule